// File: doc/BRIEF.md
# Transceiver status indicator controller

This block produces the six status outputs of a 10 Mb/s Ethernet transceiver that has a twisted-pair port and an attachment-unit port. Three outputs are active-low activity lamps for transmit, receive and collision. Each lamp blinks at about 10 Hz with a 50% duty cycle for as long as its activity lasts. The other three outputs report twisted-pair link state, reversed receive polarity and jabber. Line detection happens upstream, and the pad ring turns each value/enable pair into a tri-state pin.

A single free-running timebase divides the system clock down to the blink half-period, which lasts CLK_HZ/20 cycles. Each lamp has its own hold timer. An activity pulse reloads that timer to one full blink period (2·CLK_HZ/20 cycles), so even a single-cycle burst stays visible. Each output is delivered as a value bit and an output-enable bit. The enables depend on standby and on which port is selected.

Top module: `xcvr_status_ind`

## Requirements
- R1: Output bit positions are 0 transmit lamp, 1 receive lamp, 2 collision lamp, 3 link, 4 polarity, 5 jabber. While a lamp is active, its value is 0 during odd-numbered half-periods of the timebase and 1 during even-numbered ones. A half-period lasts CLK_HZ/20 clocks and is counted from reset release, with the first half-period numbered 0.
- R2: A lamp whose trigger has not been sampled high within the last 2·CLK_HZ/20 rising edges has value 1.
- R3: A trigger sampled high at one edge keeps the lamp active after that edge and for 2·CLK_HZ/20 − 1 further edges. A new trigger restarts this window.
- R4: The jabber output value equals the jabber input. While jabber is high, it acts as a continuous collision trigger.
- R5: In twisted-pair mode, the link value is 0 when the link is good and 1 when it has failed.
- R6: In twisted-pair mode, the polarity value is 0 only when the link is good, auto-correction is enabled and the pair is reversed. It is 1 in every other case, so a failed link forces it high.
- R7: When the attachment-unit port is selected (`tp_sel_i` = 0), the enables of bits 3 to 5 are 0.
- R8: In standby, all six enables are 0.
- R9: Outside standby, the three lamp enables are 1 in either port mode. With the twisted-pair port selected, the three diagnostic enables are also 1.
- R10: During reset, all lamp values are 1. On reset release the timebase restarts at half-period 0 and every hold timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_act_i | input | 1 | Transmit activity pulse |
| rx_act_i | input | 1 | Receive activity pulse |
| col_act_i | input | 1 | Collision activity pulse |
| link_good_i | input | 1 | Twisted-pair link integrity good |
| pol_rev_i | input | 1 | Twisted-pair receive pair reversed |
| apc_en_i | input | 1 | Auto-polarity correction enabled |
| jabber_i | input | 1 | Jabber condition present |
| tp_sel_i | input | 1 | 1 = twisted-pair port, 0 = attachment-unit port |
| standby_i | input | 1 | Standby: release all outputs |
| status_val_o | output | 6 | Output values, bit map per R1 |
| status_oe_o | output | 6 | Output enables, same bit map |

## Verification
The bench builds the block with CLK_HZ = 200. That gives a 10-cycle half-period and a 20-cycle hold, so every phase of the blink and every edge of the hold window is reached within a few hundred cycles. It steps through all 64 combinations of the six static inputs and checks every output in every cycle against a model that derives the blink phase and the hold window from edge counts. It then places single pulses at every offset across a full blink period and runs overlapping bursts, a continuous jabber, and pulses arriving during standby.

// File: rtl/xsi_pkg.sv
package xsi_pkg;

    localparam int N_ACT  = 3;
    localparam int N_DIAG = 3;
    localparam int N_STAT = N_ACT + N_DIAG;

    localparam int IDX_TX   = 0;
    localparam int IDX_RX   = 1;
    localparam int IDX_COL  = 2;
    localparam int IDX_LINK = 0;
    localparam int IDX_POL  = 1;
    localparam int IDX_JAB  = 2;

    localparam int BLINK_HZ_X2 = 20;

    typedef struct packed {
        logic val;
        logic oe;
    } pin_drv_t;

    typedef struct packed {
        logic link_ok;
        logic reversed;
        logic apc_en;
        logic jabber;
    } tp_diag_t;

    function automatic int half_cycles(input int clk_hz);
        return (clk_hz / BLINK_HZ_X2 < 1) ? 1 : clk_hz / BLINK_HZ_X2;
    endfunction

endpackage

// File: rtl/blink_timebase.sv
module blink_timebase #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst,
    output logic low_phase_o
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            low_phase_o <= 1'b0;
        end else if (cnt_q == CW'(HALF - 1)) begin
            cnt_q       <= '0;
            low_phase_o <= ~low_phase_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/activity_lamp.sv
module activity_lamp
    import xsi_pkg::*;
#(
    parameter int HOLD = 20
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trig_i,
    input  logic     low_phase_i,
    input  logic     standby_i,
    output pin_drv_t drv_o
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_q;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (trig_i) begin
            hold_q <= HW'(HOLD);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign active = (hold_q != '0);

    always_comb begin
        drv_o.val = ~(active & low_phase_i);
        drv_o.oe  = ~standby_i;
    end
endmodule

// File: rtl/diag_drive.sv
module diag_drive
    import xsi_pkg::*;
(
    input  tp_diag_t              diag_i,
    input  logic                  tp_sel_i,
    input  logic                  standby_i,
    output pin_drv_t [N_DIAG-1:0] drv_o
);
    logic en;
    logic pol_fault;

    assign en        = tp_sel_i & ~standby_i;
    assign pol_fault = diag_i.link_ok & diag_i.apc_en & diag_i.reversed;

    always_comb begin
        drv_o[IDX_LINK].val = ~diag_i.link_ok;
        drv_o[IDX_POL].val  = ~pol_fault;
        drv_o[IDX_JAB].val  = diag_i.jabber;
        for (int i = 0; i < N_DIAG; i++) begin
            drv_o[i].oe = en;
        end
    end
endmodule

// File: rtl/xcvr_status_ind.sv
module xcvr_status_ind
    import xsi_pkg::*;
#(
    parameter int CLK_HZ = 20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_act_i,
    input  logic              rx_act_i,
    input  logic              col_act_i,
    input  logic              link_good_i,
    input  logic              pol_rev_i,
    input  logic              apc_en_i,
    input  logic              jabber_i,
    input  logic              tp_sel_i,
    input  logic              standby_i,
    output logic [N_STAT-1:0] status_val_o,
    output logic [N_STAT-1:0] status_oe_o
);
    localparam int HALF = half_cycles(CLK_HZ);
    localparam int HOLD = 2 * HALF;

    logic                  low_phase;
    logic [N_ACT-1:0]      trig;
    tp_diag_t              diag;
    pin_drv_t [N_STAT-1:0] drv;

    blink_timebase #(.HALF(HALF)) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .low_phase_o(low_phase)
    );

    // jabber counts as sustained collision activity
    always_comb begin
        trig[IDX_TX]  = tx_act_i;
        trig[IDX_RX]  = rx_act_i;
        trig[IDX_COL] = col_act_i | jabber_i;
    end

    for (genvar g = 0; g < N_ACT; g++) begin : g_lamp
        activity_lamp #(.HOLD(HOLD)) u_lamp (
            .clk        (clk),
            .rst        (rst),
            .trig_i     (trig[g]),
            .low_phase_i(low_phase),
            .standby_i  (standby_i),
            .drv_o      (drv[g])
        );
    end

    always_comb begin
        diag.link_ok  = link_good_i;
        diag.reversed = pol_rev_i;
        diag.apc_en   = apc_en_i;
        diag.jabber   = jabber_i;
    end

    diag_drive u_diag (
        .diag_i   (diag),
        .tp_sel_i (tp_sel_i),
        .standby_i(standby_i),
        .drv_o    (drv[N_STAT-1:N_ACT])
    );

    for (genvar g = 0; g < N_STAT; g++) begin : g_pins
        assign status_val_o[g] = drv[g].val;
        assign status_oe_o[g]  = drv[g].oe;
    end
endmodule

// File: rtl/xcvr_status_chk.sv
module xcvr_status_chk #(
    parameter int CLK_HZ = 20_000_000
) (
    input logic       clk,
    input logic       rst,
    input logic       tx_act_i,
    input logic       link_good_i,
    input logic       pol_rev_i,
    input logic       apc_en_i,
    input logic       jabber_i,
    input logic       tp_sel_i,
    input logic       standby_i,
    input logic [5:0] status_val_o,
    input logic [5:0] status_oe_o
);
    localparam int HALF = xsi_pkg::half_cycles(CLK_HZ);
    localparam int HOLD = 2 * HALF;
    localparam int SW   = $clog2(HOLD + 2) + 1;

    logic [SW-1:0] since_tx;

    always_ff @(posedge clk) begin
        if (rst)                          since_tx <= SW'(HOLD + 1);
        else if (tx_act_i)                since_tx <= SW'(1);
        else if (since_tx <= SW'(HOLD))   since_tx <= since_tx + 1'b1;
    end

    // R8
    stby_release_chk: assert property (@(posedge clk) disable iff (rst)
        standby_i |-> status_oe_o == 6'b000000);

    // R7
    aui_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && !tp_sel_i) |-> (status_oe_o == 6'b000111));

    // R6
    lfail_pol_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && tp_sel_i && !link_good_i) |-> (status_val_o[4] && status_val_o[3]));

    // R6
    pol_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && tp_sel_i && link_good_i && apc_en_i && pol_rev_i) |-> !status_val_o[4]);

    // R4
    jab_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && tp_sel_i) |-> (status_val_o[5] == jabber_i));

    // R2
    tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_tx > SW'(HOLD) && !standby_i) |-> status_val_o[0]);
endmodule

bind xcvr_status_ind xcvr_status_chk #(.CLK_HZ(CLK_HZ)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_act_i    (tx_act_i),
    .link_good_i (link_good_i),
    .pol_rev_i   (pol_rev_i),
    .apc_en_i    (apc_en_i),
    .jabber_i    (jabber_i),
    .tp_sel_i    (tp_sel_i),
    .standby_i   (standby_i),
    .status_val_o(status_val_o),
    .status_oe_o (status_oe_o)
);

// File: tb/test_xcvr_status_ind.sv
module test_xcvr_status_ind;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 200;
    localparam int HALF       = CLK_HZ / 20;
    localparam int HOLD       = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_act, rx_act, col_act, link_good, pol_rev, apc_en, jabber, tp_sel, standby;
    logic [5:0] sval, soe;

    int e;
    int last_trig [3];
    int n_cmp = 0;
    int n_bad = 0;

    xcvr_status_ind #(.CLK_HZ(CLK_HZ)) i_xcvr_status_ind (
        .clk(clk), .rst(rst), .tx_act_i(tx_act), .rx_act_i(rx_act), .col_act_i(col_act),
        .link_good_i(link_good), .pol_rev_i(pol_rev), .apc_en_i(apc_en), .jabber_i(jabber),
        .tp_sel_i(tp_sel), .standby_i(standby), .status_val_o(sval), .status_oe_o(soe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic cmp(input logic got, input logic exp, input string req, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at edge %0d: got %b expected %b", req, what, e, got, exp);
        end
    endtask

    task automatic check_all(input string sec);
        bit    low_half;
        bit    act;
        logic  exp_pol;
        low_half = ((e / HALF) % 2) == 1;
        for (int i = 0; i < 3; i++) begin
            if (standby) begin
                cmp(soe[i], 1'b0, "R8", {sec, " lamp oe"});
            end else begin
                cmp(soe[i], 1'b1, "R9", {sec, " lamp oe"});
                act = (e - last_trig[i]) < HOLD;
                cmp(sval[i], ~(act & low_half), act ? "R1" : "R2", {sec, " lamp val"});
            end
        end
        if (standby) begin
            for (int i = 3; i < 6; i++) cmp(soe[i], 1'b0, "R8", {sec, " diag oe"});
        end else if (!tp_sel) begin
            for (int i = 3; i < 6; i++) cmp(soe[i], 1'b0, "R7", {sec, " diag oe"});
        end else begin
            for (int i = 3; i < 6; i++) cmp(soe[i], 1'b1, "R9", {sec, " diag oe"});
            cmp(sval[3], ~link_good, "R5", {sec, " link"});
            exp_pol = link_good ? ~(apc_en & pol_rev) : 1'b1;
            cmp(sval[4], exp_pol, "R6", {sec, " polarity"});
            cmp(sval[5], jabber, "R4", {sec, " jabber"});
        end
    endtask

    task automatic step(input string sec);
        @(posedge clk);
        e++;
        if (tx_act)           last_trig[0] = e;
        if (rx_act)           last_trig[1] = e;
        if (col_act | jabber) last_trig[2] = e;
        @(negedge clk);
        check_all(sec);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        {tx_act, rx_act, col_act, pol_rev, apc_en, jabber, standby} = '0;
        link_good = 1'b1;
        tp_sel    = 1'b1;
        e = 0;
        for (int i = 0; i < 3; i++) last_trig[i] = -1000;

        // R10: lamps high while in reset, even with activity present
        tx_act = 1'b1; rx_act = 1'b1; col_act = 1'b1;
        repeat (HALF + 3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) cmp(sval[i], 1'b1, "R10", "reset lamp val");
        tx_act = 1'b0; rx_act = 1'b0; col_act = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // static sweep over all six level inputs (R4 R5 R6 R7 R8 R9)
        for (int c = 0; c < 64; c++) begin
            {standby, tp_sel, jabber, apc_en, pol_rev, link_good} = 6'(c);
            repeat (3) step("sweep");
        end
        {standby, jabber, apc_en, pol_rev} = '0;
        link_good = 1'b1;
        tp_sel    = 1'b1;
        repeat (HOLD + 2) step("settle");

        // R3: single pulse at every offset within a blink period
        for (int off = 0; off < HOLD; off++) begin
            repeat (off + 1) step("R3 pre");
            tx_act = 1'b1;
            step("R3 pulse");
            tx_act = 1'b0;
            repeat (HOLD + 2) step("R3 hold");
        end

        // R3: retriggering receive bursts, then a lone collision
        for (int k = 0; k < 8; k++) begin
            rx_act = 1'b1;
            step("R3 burst");
            rx_act = 1'b0;
            repeat (6 + k) step("R3 burst gap");
        end
        col_act = 1'b1;
        step("R1 col");
        col_act = 1'b0;
        repeat (HOLD + 3) step("R1 col tail");

        // R4: sustained jabber blinks the collision lamp
        jabber = 1'b1;
        repeat (3 * HOLD) step("R4 jabber");
        jabber = 1'b0;
        repeat (HOLD + 3) step("R4 release");

        // R8: activity during standby, then recovery; also AUI mode (R7)
        standby = 1'b1;
        tx_act  = 1'b1;
        rx_act  = 1'b1;
        repeat (5) step("R8 standby");
        tx_act  = 1'b0;
        rx_act  = 1'b0;
        step("R8 standby");
        standby = 1'b0;
        tp_sel  = 1'b0;
        repeat (HOLD + 3) step("R7 aui");
        tp_sel  = 1'b1;
        step("R9 tp");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule